// File: doc/BRIEF.md
# Four-Channel Interrupt Aggregator with Readiness Signalling

This block gathers interrupt causes from four serial channels and merges them into one active-low pin and one global summary byte. Each channel keeps three lower-level pending registers: line events, status events and special-character events. Each of these has its own enable mask. The enabled, pending bits of each lower-level register collapse into one summary bit of the channel's top-level register. Five further top-level bits are set directly by their own event inputs. A channel counts as interrupting when any of its top-level bits is both pending and enabled. The global byte shows that condition for all four channels at once.

After reset the pin has a second job. It stays low while an internal start-up delay runs. It then rises to tell software that the block can be programmed. It behaves as an interrupt line only after software sets a select bit in the mode register. Until then it stays high whatever is pending. Pending bits are sticky. Software clears them by reading the register that holds them.

Top module: `irq_agg_top`

## Requirements
- R1: `irq_n` is low during reset. After `rst_n` is released, the reset synchroniser adds two clock edges, and then `INIT_CYCLES` further edges must pass before the block is ready. `irq_n` rises at the first sample after rising edge `INIT_CYCLES+2`. Readiness is never lost until the next reset.
- R2: While ready and with the select bit clear, `irq_n` stays high even when enabled causes are pending.
- R3: While ready and with the select bit set, `irq_n` is low exactly when at least one channel has a top-level bit that is both pending and enabled.
- R4: The pending registers are line (index 2), status (index 4) and special (index 6). An event pulse sets the matching bit. The bit then holds until software reads that register, and the read clears it. Writes to these registers have no effect. The enable masks are at indices 3, 5 and 7. Channel register address = {1'b0, ch[1:0], idx[2:0]}.
- R5: An event that arrives in the same cycle as a clearing read of its register survives the read. The read returns the old contents, and the new bit stays pending afterwards.
- R6: Top-level register (index 0) bits 0, 1 and 2 are the OR of the enabled pending bits of the line, status and special registers. Reading the top-level register does not clear these bits.
- R7: Top-level bits 7..3 are set by the direct event inputs `top_ev` (input bit j of a channel sets bit j+3). A read of the top-level register clears them. The top-level enable mask is at index 1.
- R8: The global status byte is at address 0x20. Bit c is 1 when channel c has an enabled pending top-level bit. Bits 7..4 read as zero. Reading this byte changes nothing.
- R9: A cause that is pending but masked off contributes nothing to the top-level summary bits, the global byte or the pin.
- R10: Before the block is ready, register writes are ignored, reads return zero, and reads clear nothing.
- R11: The mode register is at address 0x21, with the select bit at bit 0. When the select bit is written back to 0, the pin returns to high while causes remain pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_ev | input | NCH*W | Line event pulses, byte c for channel c |
| sts_ev | input | NCH*W | Status event pulses, byte c for channel c |
| spcl_ev | input | NCH*W | Special-character event pulses, byte c for channel c |
| top_ev | input | NCH*(W-3) | Direct top-level event pulses, five bits per channel |
| reg_rd | input | 1 | Read strobe; a read clears the pending register it addresses |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data for the current address |
| irq_n | output | 1 | Readiness indicator after reset, then active-low interrupt |

## Verification
A clearing read and a new event on the same pending register can land in the same clock cycle. The bench provokes this collision twice from the falling edge. In one case the read strobe and an event pulse on a different bit are raised together. In the other case they are raised on the bit being read. The bench judges the outcome by the value returned during the read and by a second read afterwards: the old bits must be gone and the newly arrived bit must remain. The start-up phase is judged in a similar way, by counting edges from reset release and checking that register accesses made before readiness leave no trace.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef enum logic [2:0] {
    RI_TOP     = 3'd0,
    RI_TOP_EN  = 3'd1,
    RI_LINE    = 3'd2,
    RI_LINE_EN = 3'd3,
    RI_STS     = 3'd4,
    RI_STS_EN  = 3'd5,
    RI_SPCL    = 3'd6,
    RI_SPCL_EN = 3'd7
  } reg_idx_e;

  localparam logic [2:0] GI_STAT = 3'd0;
  localparam logic [2:0] GI_MODE = 3'd1;

  localparam int unsigned N_LOW = 3;

endpackage

// File: rtl/irq_low_reg.sv
module irq_low_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic         rd_clr,
  input  logic         en_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend,
  output logic [W-1:0] en,
  output logic         summary
);

  logic [W-1:0] pend_q, pend_d;
  logic [W-1:0] en_q, en_d;

  // The read returns the current value, so all bits are cleared and new events are merged in.
  always_comb begin
    pend_d = rd_clr ? ev : (pend_q | ev);
    en_d   = en_wr ? wdata : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end

  assign pend    = pend_q;
  assign en      = en_q;
  assign summary = |(pend_q & en_q);

endmodule

// File: rtl/irq_chan.sv
module irq_chan
  import irq_agg_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_ev,
  input  logic [W-1:0] sts_ev,
  input  logic [W-1:0] spcl_ev,
  input  logic [W-4:0] top_ev,
  input  logic [2:0]   idx,
  input  logic         rd_stb,
  input  logic         wr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         chan_irq
);

  localparam int unsigned DW = W - N_LOW;

  logic [N_LOW-1:0][W-1:0] low_ev;
  logic [N_LOW-1:0][W-1:0] low_pend;
  logic [N_LOW-1:0][W-1:0] low_en;
  logic [N_LOW-1:0]        low_sum;

  assign low_ev = {spcl_ev, sts_ev, line_ev};

  for (genvar k = 0; k < N_LOW; k++) begin : g_low
    localparam logic [2:0] PIDX = 3'(2 + 2 * k);
    localparam logic [2:0] EIDX = 3'(3 + 2 * k);
    irq_low_reg #(.W(W)) low_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev      (low_ev[k]),
      .rd_clr  (rd_stb && (idx == PIDX)),
      .en_wr   (wr_stb && (idx == EIDX)),
      .wdata   (wdata),
      .pend    (low_pend[k]),
      .en      (low_en[k]),
      .summary (low_sum[k])
    );
  end

  logic [DW-1:0] dir_q, dir_d;
  logic [W-1:0]  ten_q, ten_d;
  logic [W-1:0]  top_val;

  always_comb begin
    dir_d = (rd_stb && (idx == RI_TOP)) ? top_ev : (dir_q | top_ev);
    ten_d = (wr_stb && (idx == RI_TOP_EN)) ? wdata : ten_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      ten_q <= '0;
    end else begin
      dir_q <= dir_d;
      ten_q <= ten_d;
    end
  end

  assign top_val  = {dir_q, low_sum};
  assign chan_irq = |(top_val & ten_q);

  always_comb begin
    case (reg_idx_e'(idx))
      RI_TOP:     rdata = top_val;
      RI_TOP_EN:  rdata = ten_q;
      RI_LINE:    rdata = low_pend[0];
      RI_LINE_EN: rdata = low_en[0];
      RI_STS:     rdata = low_pend[1];
      RI_STS_EN:  rdata = low_en[1];
      RI_SPCL:    rdata = low_pend[2];
      default:    rdata = low_en[2];
    endcase
  end

endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl #(
  parameter int unsigned INIT_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_irq,
  input  logic sel_wr,
  input  logic sel_wdata,
  output logic ready,
  output logic sel,
  output logic irq_n
);

  localparam int unsigned CW = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rdy_q, rdy_d;
  logic          sel_q, sel_d;
  logic          cnt_en;

  assign cnt_en = !rdy_q;

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (cnt_en) begin
      if (cnt_q == LAST) rdy_d = 1'b1;
      else               cnt_d = cnt_q + 1'b1;
    end
    sel_d = sel_wr ? sel_wdata : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      rdy_q <= rdy_d;
      sel_q <= sel_d;
    end
  end

  assign ready = rdy_q;
  assign sel   = sel_q;
  assign irq_n = rdy_q ? (sel_q ? !any_irq : 1'b1) : 1'b0;

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int unsigned NCH         = 4,
  parameter int unsigned W           = 8,
  parameter int unsigned INIT_CYCLES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH*W-1:0]     line_ev,
  input  logic [NCH*W-1:0]     sts_ev,
  input  logic [NCH*W-1:0]     spcl_ev,
  input  logic [NCH*(W-3)-1:0] top_ev,
  input  logic                 reg_rd,
  input  logic                 reg_wr,
  input  logic [5:0]           reg_addr,
  input  logic [W-1:0]         reg_wdata,
  output logic [W-1:0]         reg_rdata,
  output logic                 irq_n
);

  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned AW  = 1 + CHW + 3;
  localparam int unsigned DW  = W - N_LOW;

  // reset: asynchronous assertion, release through two flops
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic           ready;
  logic           sel;
  logic           acc_rd, acc_wr;
  logic           is_glob;
  logic [CHW-1:0] ch_sel;
  logic [2:0]     ridx;

  assign is_glob = reg_addr[AW-1];
  assign ch_sel  = reg_addr[AW-2:3];
  assign ridx    = reg_addr[2:0];
  assign acc_rd  = ready && reg_rd;
  assign acc_wr  = ready && reg_wr;

  logic [NCH-1:0]        glob;
  logic [NCH-1:0][W-1:0] ch_rdata;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = !is_glob && (ch_sel == CHW'(c));
    irq_chan #(.W(W)) chan_i (
      .clk      (clk),
      .rst_n    (rst_i),
      .line_ev  (line_ev[c*W +: W]),
      .sts_ev   (sts_ev[c*W +: W]),
      .spcl_ev  (spcl_ev[c*W +: W]),
      .top_ev   (top_ev[c*DW +: DW]),
      .idx      (ridx),
      .rd_stb   (acc_rd && hit),
      .wr_stb   (acc_wr && hit),
      .wdata    (reg_wdata),
      .rdata    (ch_rdata[c]),
      .chan_irq (glob[c])
    );
  end

  irq_pin_ctrl #(.INIT_CYCLES(INIT_CYCLES)) pin_i (
    .clk       (clk),
    .rst_n     (rst_i),
    .any_irq   (|glob),
    .sel_wr    (acc_wr && is_glob && (ridx == GI_MODE)),
    .sel_wdata (reg_wdata[0]),
    .ready     (ready),
    .sel       (sel),
    .irq_n     (irq_n)
  );

  logic [W-1:0] glob_byte;
  assign glob_byte = W'(glob);

  always_comb begin
    reg_rdata = '0;
    if (ready) begin
      if (!is_glob)                reg_rdata = ch_rdata[ch_sel];
      else if (ridx == GI_STAT)    reg_rdata = glob_byte;
      else if (ridx == GI_MODE)    reg_rdata = W'(sel);
    end
  end

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned W   = 8,
  parameter int unsigned AW  = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ready,
  input logic           sel,
  input logic           irq_n,
  input logic [NCH-1:0] glob,
  input logic [AW-1:0]  reg_addr,
  input logic [W-1:0]   reg_rdata
);

  localparam logic [AW-1:0] GADDR = AW'(1) << (AW - 1);

  p_init_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !irq_n);

  p_ready_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !sel) |-> irq_n);

  p_pin_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && sel) |-> (irq_n == (glob == '0)));

  p_glob_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && reg_addr == GADDR) |-> (reg_rdata[W-1:NCH] == '0));

  p_no_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (reg_rdata == '0));

endmodule

bind irq_agg_top irq_agg_chk #(.NCH(NCH), .W(W), .AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_i),
  .ready     (ready),
  .sel       (sel),
  .irq_n     (irq_n),
  .glob      (glob),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata)
);

// File: tb/irq_agg_top_tb_top.sv
`timescale 1ns/1ps
module irq_agg_top_tb_top;

  localparam int NCH  = 4;
  localparam int W    = 8;
  localparam int INIT = 64;
  localparam int DW   = W - 3;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [NCH*W-1:0]   line_ev, sts_ev, spcl_ev;
  logic [NCH*DW-1:0]  top_ev;
  logic               reg_rd, reg_wr;
  logic [5:0]         reg_addr;
  logic [W-1:0]       reg_wdata;
  logic [W-1:0]       reg_rdata;
  logic               irq_n;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  irq_agg_top #(.NCH(NCH), .W(W), .INIT_CYCLES(INIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_ev(line_ev), .sts_ev(sts_ev),
    .spcl_ev(spcl_ev), .top_ev(top_ev), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_n(irq_n)
  );

  function automatic logic [5:0] ca(input int ch, input int idx);
    return {1'b0, 2'(ch), 3'(idx)};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [W-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // kind: 0 line, 1 status, 2 special, 3 direct top
  task automatic pulse(input int kind, input int ch, input int b);
    @(negedge clk);
    case (kind)
      0: line_ev[ch*W + b] = 1'b1;
      1: sts_ev[ch*W + b]  = 1'b1;
      2: spcl_ev[ch*W + b] = 1'b1;
      default: top_ev[ch*DW + b] = 1'b1;
    endcase
    @(negedge clk);
    line_ev = '0; sts_ev = '0; spcl_ev = '0; top_ev = '0;
  endtask

  task automatic t_init_count;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 pin low in reset", irq_n, 0);
    rst_n = 1'b1;
    repeat (INIT + 1) @(posedge clk);
    @(negedge clk);
    check("R1 pin low one edge before ready", irq_n, 0);
    @(posedge clk);
    @(negedge clk);
    check("R1 pin high at ready", irq_n, 1);
    repeat (5) @(negedge clk);
    check("R1 ready held", irq_n, 1);
  endtask

  task automatic t_early_access;
    logic [W-1:0] d;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    wr(6'h21, 8'h01);
    wr(ca(0, 1), 8'hFF);
    wr(ca(0, 3), 8'hFF);
    line_ev[0] = 1'b1;
    @(negedge clk);
    line_ev = '0;
    rd(ca(0, 2), d);
    check("R10 read before ready is zero", d, 0);
    for (int i = 0; i < 4 * INIT && irq_n == 1'b0; i++) @(negedge clk);
    check("R1 ready reached", irq_n, 1);
    rd(6'h21, d);
    check("R10 mode write ignored", d, 0);
    rd(ca(0, 1), d);
    check("R10 enable write ignored", d, 0);
    rd(ca(0, 2), d);
    check("R10 early read did not clear", d, 8'h01);
    rd(ca(0, 2), d);
    check("R4 second read cleared", d, 0);
  endtask

  task automatic t_idle_mode;
    logic [W-1:0] d;
    wr(ca(0, 1), 8'h01);
    wr(ca(0, 3), 8'h01);
    pulse(0, 0, 0);
    check("R2 pin high without select", irq_n, 1);
    rd(6'h20, d);
    check("R8 global byte ch0", d, 8'h01);
    rd(6'h20, d);
    check("R8 global read has no side effect", d, 8'h01);
  endtask

  task automatic t_pin_mode;
    logic [W-1:0] d;
    wr(6'h21, 8'h01);
    rd(6'h21, d);
    check("R11 select readback", d, 1);
    check("R3 pin low on enabled cause", irq_n, 0);
    wr(ca(0, 2), 8'hF0);
    rd(ca(0, 2), d);
    check("R4 read returns pending, write ignored", d, 8'h01);
    check("R3 pin released after clear", irq_n, 1);
    rd(ca(0, 2), d);
    check("R4 cleared by read", d, 0);
    pulse(0, 0, 0);
    check("R3 pin low again", irq_n, 0);
    wr(6'h21, 8'h00);
    check("R11 pin high after select cleared", irq_n, 1);
    rd(ca(0, 2), d);
    check("R4 pending kept while deselected", d, 8'h01);
  endtask

  task automatic t_summary;
    logic [W-1:0] d;
    wr(ca(2, 5), 8'h08);
    wr(ca(2, 1), 8'h02);
    pulse(1, 2, 3);
    pulse(1, 2, 4);
    rd(ca(2, 0), d);
    check("R6 status summary bit", d, 8'h02);
    rd(ca(2, 0), d);
    check("R6 top read does not clear summary", d, 8'h02);
    wr(ca(3, 1), 8'hFF);
    pulse(2, 3, 2);
    rd(ca(3, 0), d);
    check("R9 masked special cause not summarised", d, 0);
    rd(6'h20, d);
    check("R9 global shows only ch2", d, 8'h04);
    wr(6'h21, 8'h01);
    rd(ca(2, 4), d);
    check("R6 status register contents", d, 8'h18);
    check("R9 pin idle with only masked cause", irq_n, 1);
    rd(ca(3, 6), d);
    check("R9 masked cause recorded", d, 8'h04);
    wr(6'h21, 8'h00);
  endtask

  task automatic t_direct;
    logic [W-1:0] d;
    wr(ca(1, 1), 8'h08);
    pulse(3, 1, 0);
    pulse(3, 1, 4);
    rd(6'h20, d);
    check("R7 direct cause in global", d, 8'h02);
    rd(ca(1, 0), d);
    check("R7 direct bits in top register", d, 8'h88);
    rd(ca(1, 0), d);
    check("R7 cleared by top read", d, 0);
  endtask

  task automatic t_collide;
    logic [W-1:0] d;
    pulse(0, 1, 0);
    @(negedge clk);
    reg_addr = ca(1, 2); reg_rd = 1'b1; line_ev[1*W + 5] = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; line_ev = '0;
    check("R5 read returns old bits", d, 8'h01);
    rd(ca(1, 2), d);
    check("R5 new event survived read", d, 8'h20);
    pulse(0, 1, 0);
    @(negedge clk);
    reg_addr = ca(1, 2); reg_rd = 1'b1; line_ev[1*W + 0] = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; line_ev = '0;
    rd(ca(1, 2), d);
    check("R5 same bit re-set survives", d, 8'h01);
  endtask

  task automatic t_all_channels;
    logic [W-1:0] d;
    for (int c = 0; c < NCH; c++) begin
      wr(ca(c, 1), 8'h80);
      pulse(3, c, 4);
    end
    rd(6'h20, d);
    check("R8 all channels, upper bits zero", d, 8'h0F);
    wr(6'h21, 8'h01);
    for (int c = 0; c < NCH; c++) rd(ca(c, 0), d);
    check("R3 pin released when last cleared", irq_n, 1);
  endtask

  initial begin
    rst_n = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    line_ev = '0; sts_ev = '0; spcl_ev = '0; top_ev = '0;
    t_init_count();
    t_early_access();
    t_idle_mode();
    t_pin_mode();
    t_summary();
    t_direct();
    t_collide();
    t_all_channels();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule